// File: doc/BRIEF.md
# Strobed Parallel-to-Serial Link Transmitter

This block accepts parallel words from a host over a strobe/acknowledge handshake and sends them out as a serial bit stream. A word is taken when the strobe rises. If the single-entry capture latch still holds a word that has not been sent, the block holds acknowledge low until the next symbol boundary frees the latch. A second register, the shift register, reloads from the latch once per symbol period and sends the symbol MSB first, one bit per clock. When no word is waiting, a fixed idle symbol is sent.

A static two-bit split input decides how the ten shared data pins and the two dedicated command pins divide into data and command fields: 8/4, 9/3 or 10/2. A word whose command field is nonzero goes out as a command symbol, and its data bits are dropped. The line is NRZI coded in normal operation and plain NRZ when the test input is high.

Top module: `link_tx`

## Requirements
- R1: While rst_ni is low, ack_o and ser_o are 0.
- R2: When strb_i is sampled rising and the capture latch is empty, or is being emptied in that same cycle, the word is captured and ack_o is 1 from the next clock edge on.
- R3: When strb_i rises while the latch still holds an unsent word, ack_o stays 0 until the next symbol boundary. At that boundary the word is captured and ack_o rises. The unsent word goes out first, then the new one in the following symbol.
- R4: ack_o is 1 only while strb_i stays high, and it falls on the edge after strb_i is sampled low. A strobe that drops while its word is still waiting is discarded: it gets no acknowledge and its word is never sent.
- R5: With mode_i = 00 (8/4 split), data is data_i[7:0]. The command field is {data_i[8], data_i[9], cmd_i[1], cmd_i[0]}, from MSB to LSB.
- R6: With mode_i = 01 (9/3 split), data is data_i[8:0]. The command field is {data_i[9], cmd_i[1], cmd_i[0]}.
- R7: With mode_i = 10 or 11 (10/2 split), data is data_i[9:0] and the command field is cmd_i[1:0].
- R8: A word with an all-zero command field is sent as the 12-bit symbol {2'b01, data zero-extended to 10 bits}. A word with a nonzero command field is sent as {2'b10, command zero-extended to 10 bits}, and its data bits are ignored.
- R9: A symbol is 12 bits, sent MSB first. The shift register loads on the first clock edge after reset and then every 12 clocks. The first bit of a symbol reaches the line one edge after its load. When no word is waiting, the idle symbol 12'hC00 is loaded.
- R10: With test_i = 0 the line is NRZI coded: ser_o toggles for a 1 bit and holds for a 0 bit.
- R11: With test_i = 1 the line is NRZ coded: ser_o equals the bit being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; symbol boundaries are derived from it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Static data/command split select |
| test_i | input | 1 | 1 selects NRZ line coding, 0 selects NRZI |
| strb_i | input | 1 | Host strobe; the rising edge offers a word |
| data_i | input | 10 | Data pins; the upper two may act as command bits |
| cmd_i | input | 2 | Dedicated command pins |
| ack_o | output | 1 | Word accepted, held while the strobe stays high |
| ser_o | output | 1 | Serial line output |

## Verification
The bench uses the default parameters: ten shared data pins and two command pins, which give a 12-bit symbol. At this size every split mapping can be tested, including each upper shared pin acting as a command bit. The 12-clock period is short enough that the bench can place strobes at exact offsets from a boundary. That lets it hit the occupied-latch deferral and the withdrawn strobe. A monitor decodes the line under both codings and rebuilds every symbol by its load index.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
  typedef enum logic [1:0] {
    SPLIT_8_4  = 2'b00,
    SPLIT_9_3  = 2'b01,
    SPLIT_10_2 = 2'b10,
    SPLIT_ALT  = 2'b11
  } split_e;

  localparam logic [1:0] KIND_DATA = 2'b01;
  localparam logic [1:0] KIND_CMD  = 2'b10;
  localparam logic [1:0] KIND_IDLE = 2'b11;
endpackage

// File: rtl/link_tx_accept.sv
module link_tx_accept
  import link_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CMD_W  = 2,
  localparam int unsigned SYM_W = DATA_W + 2,
  localparam int unsigned CF_W  = CMD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              load_i,
  output logic              ack_o,
  output logic              full_o,
  output logic [SYM_W-1:0]  word_o
);
  logic              strb_q, pend_q, full_q, ack_q;
  logic [SYM_W-1:0]  word_q;
  logic [DATA_W-1:0] data_w;
  logic [CF_W-1:0]   cmd_w;
  logic [SYM_W-1:0]  sym_w;
  logic              rise, free, take;

  // shared upper pins switch role with the split
  always_comb begin
    unique case (split_e'(mode_i))
      SPLIT_8_4: begin
        data_w = {2'b00, data_i[DATA_W-3:0]};
        cmd_w  = {data_i[DATA_W-2], data_i[DATA_W-1], cmd_i};
      end
      SPLIT_9_3: begin
        data_w = {1'b0, data_i[DATA_W-2:0]};
        cmd_w  = {1'b0, data_i[DATA_W-1], cmd_i};
      end
      default: begin
        data_w = data_i;
        cmd_w  = {2'b00, cmd_i};
      end
    endcase
    sym_w = (|cmd_w) ? {KIND_CMD, {(DATA_W-CF_W){1'b0}}, cmd_w}
                     : {KIND_DATA, data_w};
  end

  assign rise = strb_i & ~strb_q;
  assign free = ~full_q | load_i;
  assign take = (rise | pend_q) & strb_i & free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      pend_q <= 1'b0;
      full_q <= 1'b0;
      ack_q  <= 1'b0;
      word_q <= '0;
    end else begin
      strb_q <= strb_i;
      pend_q <= strb_i & ~take & (rise | pend_q);
      full_q <= take | (full_q & ~load_i);
      ack_q  <= strb_i & (ack_q | take);
      if (take) word_q <= sym_w;
    end
  end

  assign ack_o  = ack_q;
  assign full_o = full_q;
  assign word_o = word_q;
endmodule

// File: rtl/link_tx_shift.sv
module link_tx_shift #(
  parameter int unsigned SYM_W = 12,
  parameter logic [SYM_W-1:0] IDLE_SYM = '0,
  localparam int unsigned CNT_W = $clog2(SYM_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_i,
  input  logic [SYM_W-1:0] word_i,
  output logic             load_o,
  output logic             bit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SYM_W-1:0] sreg_q;

  assign load_o = (cnt_q == CNT_W'(SYM_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(SYM_W-1);
      sreg_q <= '0;
    end else if (load_o) begin
      cnt_q  <= '0;
      sreg_q <= full_i ? word_i : IDLE_SYM;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      sreg_q <= {sreg_q[SYM_W-2:0], 1'b0};
    end
  end

  assign bit_o = sreg_q[SYM_W-1];
endmodule

// File: rtl/link_tx_line.sv
module link_tx_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nrz_i,
  input  logic bit_i,
  output logic line_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= 1'b0;
    else if (nrz_i) line_q <= bit_i;
    else            line_q <= line_q ^ bit_i;
  end

  assign line_o = line_q;
endmodule

// File: rtl/link_tx.sv
module link_tx
  import link_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned CMD_W  = 2,
  parameter logic [DATA_W+1:0] IDLE_SYM = {KIND_IDLE, {DATA_W{1'b0}}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              test_i,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              ack_o,
  output logic              ser_o
);
  localparam int unsigned SYM_W = DATA_W + 2;

  logic             full_w, load_w, bit_w;
  logic [SYM_W-1:0] word_w;

  link_tx_accept #(.DATA_W(DATA_W), .CMD_W(CMD_W)) i_accept (
    .clk_i, .rst_ni, .mode_i, .strb_i, .data_i, .cmd_i,
    .load_i(load_w), .ack_o, .full_o(full_w), .word_o(word_w)
  );

  link_tx_shift #(.SYM_W(SYM_W), .IDLE_SYM(IDLE_SYM)) i_shift (
    .clk_i, .rst_ni, .full_i(full_w), .word_i(word_w),
    .load_o(load_w), .bit_o(bit_w)
  );

  link_tx_line i_line (
    .clk_i, .rst_ni, .nrz_i(test_i), .bit_i(bit_w), .line_o(ser_o)
  );
endmodule

// File: rtl/link_tx_chk.sv
module link_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic strb_i,
  input logic test_i,
  input logic ack_o,
  input logic ser_o,
  input logic full_i,
  input logic load_i,
  input logic bit_i
);
  AST_ACK_WITH_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(strb_i)); // R4
  AST_ACK_ON_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(!full_i || load_i)); // R3
  AST_FULL_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> full_i); // R2
  AST_LOAD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !load_i); // R9
  AST_NRZI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && !bit_i) |=> $stable(ser_o)); // R10
  AST_NRZI_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && bit_i) |=> (ser_o != $past(ser_o))); // R10
  AST_NRZ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (ser_o == $past(bit_i))); // R11
endmodule

bind link_tx link_tx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb_i), .test_i(test_i),
  .ack_o(ack_o), .ser_o(ser_o), .full_i(full_w), .load_i(load_w),
  .bit_i(bit_w)
);

// File: tb/test_link_tx.sv
module test_link_tx;
  localparam int SYM = 12;
  localparam int LOGN = 512;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       test = 1'b1;
  logic       strb = 1'b0;
  logic [9:0] data = '0;
  logic [1:0] cmd = '0;
  logic       ack, ser;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  logic prev = 1'b0;
  logic [SYM-1:0] sym_log [LOGN];

  link_tx i_link_tx (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .test_i(test),
    .strb_i(strb), .data_i(data), .cmd_i(cmd), .ack_o(ack), .ser_o(ser)
  );

  always #5 clk = ~clk;

  // line decoder: rebuild each symbol by its load index
  always begin
    @(posedge clk);
    if (rst_ni) begin
      ecnt++;
      #1;
      if (ecnt >= 2) begin
        automatic int m = (ecnt - 2) / SYM;
        automatic int p = SYM - 1 - ((ecnt - 2) % SYM);
        if (m < LOGN) sym_log[m][p] = test ? ser : (ser ^ prev);
      end
      prev = ser;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_sym(input int k);
    while (ecnt < 13 + SYM * k) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic after_load();
    do begin @(posedge clk); #2; end while (ecnt % SYM != 1);
  endtask

  task automatic send(input logic [1:0] md, input logic [9:0] d, input logic [1:0] c,
                      output int k);
    @(negedge clk);
    mode = md; data = d; cmd = c; strb = 1'b1;
    @(posedge clk); #2;
    chk(ack === 1'b1, "R2", ack, 1);
    k = (ecnt - 1) / SYM + 1;
    @(negedge clk); strb = 1'b0;
    @(posedge clk); #2;
    chk(ack === 1'b0, "R4", ack, 0);
  endtask

  task automatic t_word(input logic [1:0] md, input logic [9:0] d, input logic [1:0] c,
                        input logic [11:0] exp, input string req);
    int k;
    send(md, d, c, k);
    wait_sym(k);
    chk(sym_log[k] === exp, req, sym_log[k], exp);
  endtask

  task automatic t_reset();
    chk(ack === 1'b0 && ser === 1'b0, "R1", {ack, ser}, 0);
  endtask

  task automatic t_idle();
    wait_sym(1);
    chk(sym_log[0] === 12'hC00, "R9", sym_log[0], 12'hC00);
    chk(sym_log[1] === 12'hC00, "R9", sym_log[1], 12'hC00);
  endtask

  task automatic t_defer();
    int ka;
    logic low_ok = 1'b1;
    after_load();
    @(negedge clk); mode = 2'b10; data = 10'h011; cmd = 2'b00; strb = 1'b1;
    @(posedge clk); #2;
    chk(ack === 1'b1, "R2", ack, 1);
    ka = (ecnt - 1) / SYM + 1;
    @(negedge clk); strb = 1'b0;
    @(negedge clk); data = 10'h022; strb = 1'b1;
    do begin
      @(posedge clk); #2;
      if (ecnt % SYM != 1 && ack !== 1'b0) low_ok = 1'b0;
    end while (ecnt % SYM != 1);
    chk(low_ok, "R3", 1, 0);
    chk(ack === 1'b1, "R3", ack, 1);
    @(negedge clk); strb = 1'b0;
    wait_sym(ka + 1);
    chk(sym_log[ka] === 12'h411, "R3", sym_log[ka], 12'h411);
    chk(sym_log[ka+1] === 12'h422, "R3", sym_log[ka+1], 12'h422);
  endtask

  task automatic t_withdraw();
    int ka;
    logic low_ok = 1'b1;
    after_load();
    @(negedge clk); mode = 2'b10; data = 10'h033; cmd = 2'b00; strb = 1'b1;
    @(posedge clk); #2;
    ka = (ecnt - 1) / SYM + 1;
    @(negedge clk); strb = 1'b0;
    @(negedge clk); data = 10'h044; strb = 1'b1;
    repeat (3) @(negedge clk);
    strb = 1'b0;
    repeat (SYM + 2) begin
      @(posedge clk); #2;
      if (ack !== 1'b0) low_ok = 1'b0;
    end
    chk(low_ok, "R4", 1, 0);
    wait_sym(ka + 1);
    chk(sym_log[ka] === 12'h433, "R4", sym_log[ka], 12'h433);
    chk(sym_log[ka+1] === 12'hC00, "R4", sym_log[ka+1], 12'hC00);
  endtask

  task automatic t_ack_hold();
    @(negedge clk); mode = 2'b10; data = 10'h055; cmd = 2'b00; strb = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(ack === 1'b1, "R4", ack, 1);
    @(negedge clk); strb = 1'b0;
    @(posedge clk); #2;
    chk(ack === 1'b0, "R4", ack, 0);
    wait_sym((ecnt - 1) / SYM + 1);
  endtask

  task automatic t_nrzi();
    int k;
    @(negedge clk); test = 1'b0;
    send(2'b10, 10'h2C3, 2'b00, k);
    wait_sym(k + 1);
    chk(sym_log[k] === 12'h6C3, "R10", sym_log[k], 12'h6C3);
    chk(sym_log[k+1] === 12'hC00, "R10", sym_log[k+1], 12'hC00);
    t_word(2'b00, 10'h1A5, 2'b00, 12'h808, "R10");
    @(negedge clk); test = 1'b1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got %0h expected %0h", ecnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_idle();
    t_word(2'b00, 10'h0A5, 2'b00, 12'h4A5, "R5");
    t_word(2'b00, 10'h1A5, 2'b00, 12'h808, "R5");
    t_word(2'b00, 10'h2A5, 2'b00, 12'h804, "R5");
    t_word(2'b01, 10'h1FF, 2'b00, 12'h5FF, "R6");
    t_word(2'b01, 10'h3FF, 2'b00, 12'h804, "R6");
    t_word(2'b01, 10'h0F0, 2'b11, 12'h803, "R8");
    t_word(2'b10, 10'h3FF, 2'b00, 12'h7FF, "R7");
    t_word(2'b11, 10'h2AA, 2'b00, 12'h6AA, "R7");
    t_word(2'b10, 10'h155, 2'b01, 12'h801, "R8");
    t_word(2'b10, 10'h000, 2'b00, 12'h400, "R11");
    t_defer();
    t_withdraw();
    t_ack_hold();
    t_nrzi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule